// File: doc/BRIEF.md
# Scaled PWM Compare Timer

This block is a four-channel compare timer sitting on a simple 32-bit register bus. A 31-bit tick counter advances by one per clock while either of two run enables is set: one keeps it running, the other allows a single pass. A 16-bit window of that counter is chosen by a 4-bit shift and compared against four 16-bit thresholds. Each channel latches a pending flag, which drives its own interrupt line, whenever the window value is at or above the channel's threshold.

Channel 0 can optionally send the counter back to zero when it matches. Both a channel-0 zero return and a counter wrap end a single-pass run by clearing the single-pass enable. Software can load the counter either as a raw count or through the scaled window. It clears pending flags by writing zeros into the top bits of the control register.

Top module: `pwm_cmp_timer`

## Requirements
- R1: While reset is asserted and after it, the control word, the tick counter and all four thresholds read as zero, and every interrupt line is low.
- R2: The tick register at offset 0x08 loads the low 31 bits of a write, and bit 31 of its read value is always zero.
- R3: The counter advances by one per clock while control bit 12 (run) or bit 13 (single pass) is set, and wraps from 0x7FFFFFFF to 0. With both bits clear it holds its value.
- R4: The window register at offset 0x10 reads `(count >> shift)` masked to 16 bits, where shift is control bits 3:0. A write loads the counter with `(value[15:0] << shift)` masked to 31 bits.
- R5: Threshold n sits at offset 0x20 + 4n and keeps only the low 16 bits of a write.
- R6: Pending flag n, which is control bit 28+n and drives irq_o[n], is set on the clock edge after the one where the window value is greater than or equal to threshold n. It stays set until a control write puts a zero in that bit.
- R7: With control bit 9 (zero return) set, a channel-0 match sends the counter to 0 on the next edge and clears bit 13.
- R8: A counter wrap from 0x7FFFFFFF to 0 clears bit 13, which stops a single-pass run.
- R9: In a cycle where a control write coincides with an automatic clear of bit 13, the written value is kept. A tick or window write takes priority over a zero return or an increment in the same cycle.
- R10: Control bits 8, 10, 19:16 and 27:24 are stored and read back. They do not change counting or interrupts.
- R11: Any offset other than 0x00, 0x08, 0x10 and 0x20 to 0x2C reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, applied at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 4 | Per-channel interrupt lines, one per pending flag |

## Verification
Two kinds of write can land in the same cycle as the counter's own automatic action, and the bench provokes both. In the first, a single-pass run with zero return is set up so that channel 0 matches, and the software control write is placed on exactly that edge. The bench then expects the counter at zero, the single-pass bit still set, and pending flag 0 still clear. In the second, a tick write is aimed at the edge of a zero return. The bench expects the loaded value, with the zero return following one edge later.

// File: rtl/pwmt_pkg.sv
// Shared constants for the scaled compare timer: default widths,
// register offsets and the control-word bit positions that software decodes.
package pwmt_pkg;
    localparam int unsigned BUS_W       = 32;
    localparam int unsigned DEF_CNT_W   = 31;
    localparam int unsigned DEF_CMP_W   = 16;
    localparam int unsigned DEF_SHIFT_W = 4;
    localparam int unsigned DEF_NUM_CH  = 4;
    localparam int unsigned DEF_ADDR_W  = 8;

    localparam int unsigned OFF_CTRL    = 'h00;
    localparam int unsigned OFF_TICK    = 'h08;
    localparam int unsigned OFF_VIEW    = 'h10;
    localparam int unsigned OFF_THR     = 'h20;
    localparam int unsigned THR_STRIDE  = 4;

    localparam int unsigned BIT_ZRET    = 9;
    localparam int unsigned BIT_RUN     = 12;
    localparam int unsigned BIT_ONCE    = 13;
endpackage

// File: rtl/pwmt_counter.sv
// Tick counter: load has priority, then a return to zero, then increment.
// Assumes load and zero requests are valid for the current cycle only.
// wrap flags an increment from all-ones back to zero in this cycle.
module pwmt_counter #(
    parameter int unsigned CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             zero,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Wrap only when the increment path is the one taken.
    assign wrap = run && !load && !zero && (count == CNT_MAX);

    // Counter register with load > zero > increment priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (zero)  count <= '0;
        else if (run)   count <= count + 1'b1;
    end
endmodule

// File: rtl/pwmt_chan.sv
// One compare channel: holds its threshold and reports whether the scaled
// counter view is at or above it. Assumes wr is a decoded write strobe.
module pwmt_chan #(
    parameter int unsigned CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CMP_W-1:0] wdata,
    input  logic [CMP_W-1:0] scaled,
    output logic [CMP_W-1:0] thr,
    output logic             hit
);
    // Threshold register, written with the low bits of the bus word.
    always_ff @(posedge clk) begin
        if (!rst_n)  thr <= '0;
        else if (wr) thr <= wdata;
    end

    // Greater-or-equal comparison against the scaled view.
    assign hit = (scaled >= thr);
endmodule

// File: rtl/pwm_cmp_timer.sv
// Scaled compare timer top: register decode, control word, pending flags,
// the shared tick counter and one compare channel per interrupt line.
// Assumes single-cycle bus writes and combinational reads.
module pwm_cmp_timer
    import pwmt_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned CMP_W   = DEF_CMP_W,
    parameter int unsigned SHIFT_W = DEF_SHIFT_W,
    parameter int unsigned NUM_CH  = DEF_NUM_CH,
    parameter int unsigned ADDR_W  = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq_o
);
    localparam int unsigned IP_LSB = BUS_W - NUM_CH;

    logic [IP_LSB-1:0]  cfg_q;
    logic [NUM_CH-1:0]  ip_q;
    logic [BUS_W-1:0]   ctrl_word;
    logic [CNT_W-1:0]   count_q;
    logic [CNT_W-1:0]   load_val;
    logic [CMP_W-1:0]   scaled;
    logic [CMP_W-1:0]   thr_q [NUM_CH];
    logic [NUM_CH-1:0]  hit;
    logic [NUM_CH-1:0]  sel_thr;
    logic [SHIFT_W-1:0] shift;
    logic sel_ctrl, sel_tick, sel_view, run, zero_evt, wrap;

    // Address decode for the fixed registers.
    assign sel_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
    assign sel_tick = bus_we && (bus_addr == ADDR_W'(OFF_TICK));
    assign sel_view = bus_we && (bus_addr == ADDR_W'(OFF_VIEW));

    assign shift     = cfg_q[SHIFT_W-1:0];
    assign run       = cfg_q[BIT_RUN] | cfg_q[BIT_ONCE];
    assign scaled    = CMP_W'(count_q >> shift);
    assign zero_evt  = cfg_q[BIT_ZRET] & hit[0];
    assign ctrl_word = {ip_q, cfg_q};
    assign irq_o     = ip_q;

    // Counter load value: raw tick write or window write shifted into place.
    assign load_val = sel_tick ? bus_wdata[CNT_W-1:0]
                               : (CNT_W'(bus_wdata[CMP_W-1:0]) << shift);

    pwmt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .load     (sel_tick | sel_view),
        .load_val (load_val),
        .zero     (zero_evt),
        .count    (count_q),
        .wrap     (wrap)
    );

    // One compare channel per interrupt line.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign sel_thr[g] = bus_we &&
            (bus_addr == ADDR_W'(OFF_THR + THR_STRIDE * g));
        pwmt_chan #(.CMP_W(CMP_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (sel_thr[g]),
            .wdata  (bus_wdata[CMP_W-1:0]),
            .scaled (scaled),
            .thr    (thr_q[g]),
            .hit    (hit[g])
        );
    end

    // Control bits: a software write wins over the single-pass auto-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cfg_q <= '0;
        else if (sel_ctrl)          cfg_q <= bus_wdata[IP_LSB-1:0];
        else if (zero_evt || wrap)  cfg_q[BIT_ONCE] <= 1'b0;
    end

    // Pending flags: accumulate matches, replaced by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ip_q <= '0;
        else if (sel_ctrl) ip_q <= bus_wdata[BUS_W-1:IP_LSB];
        else               ip_q <= ip_q | hit;
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL))      bus_rdata = ctrl_word;
        else if (bus_addr == ADDR_W'(OFF_TICK)) bus_rdata = BUS_W'(count_q);
        else if (bus_addr == ADDR_W'(OFF_VIEW)) bus_rdata = BUS_W'(scaled);
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == ADDR_W'(OFF_THR + THR_STRIDE * n))
                bus_rdata = BUS_W'(thr_q[n]);
        end
    end
endmodule

// File: rtl/pwmt_checker.sv
// Temporal checks on the compare timer, attached by bind below.
module pwmt_checker
    import pwmt_pkg::*;
#(
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [NUM_CH-1:0] irq_o,
    input logic [CNT_W-1:0]  count_q,
    input logic [NUM_CH-1:0] hit,
    input logic [BUS_W-1:0]  ctrl_word
);
    logic wr_ctrl, wr_cnt, run, zret;
    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wr_cnt  = bus_we && ((bus_addr == ADDR_W'(OFF_TICK)) ||
                                (bus_addr == ADDR_W'(OFF_VIEW)));
    assign run     = ctrl_word[BIT_RUN] | ctrl_word[BIT_ONCE];
    assign zret    = ctrl_word[BIT_ZRET] & hit[0];

    assert_flag_after_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> ((irq_o & $past(hit)) == $past(hit)));
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> ((irq_o & $past(irq_o)) == $past(irq_o)));
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt && !zret) |=> $stable(count_q));
    assert_step_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_cnt && !zret) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));
    assert_zero_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (zret && !wr_cnt) |=> (count_q == '0));
    assert_zero_ends_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (zret && !wr_ctrl) |=> !ctrl_word[BIT_ONCE]);
    assert_wrap_ends_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_cnt && !zret && !wr_ctrl && (&count_q)) |=> !ctrl_word[BIT_ONCE]);
    assert_tick_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_TICK)) |-> !bus_rdata[BUS_W-1]);
    assert_hole_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == ADDR_W'('h04)) || (bus_addr == ADDR_W'('h0C))) |-> (bus_rdata == '0));
endmodule

bind pwm_cmp_timer pwmt_checker #(
    .CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)
) u_pwmt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .count_q   (count_q),
    .hit       (hit),
    .ctrl_word (ctrl_word)
);

// File: tb/test_pwm_cmp_timer.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares.
module test_pwm_cmp_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_C = 8'h00, A_T = 8'h08, A_V = 8'h10;
    localparam logic [7:0] A_H0 = 8'h20, A_H1 = 8'h24, A_H2 = 8'h28, A_H3 = 8'h2C;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;
    logic        mon_valid = 1'b0;
    sb_item_t    sb_q[$];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    pwm_cmp_timer i_pwm_cmp_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic expect_item(input bit irq, input logic [7:0] a,
                               input logic [31:0] e, input string r);
        sb_item_t it;
        @(negedge clk);
        bus_addr = a;
        it.is_irq = irq; it.exp = e; it.req = r;
        sb_q.push_back(it);
        mon_valid = 1'b1;
        @(posedge clk); #1;
        mon_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
        expect_item(1'b0, a, e, r);
    endtask

    task automatic irq_chk(input logic [3:0] e, input string r);
        expect_item(1'b1, A_C, {28'b0, e}, r);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Monitor: compares one queued expectation per valid window.
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (mon_valid && sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {28'b0, irq_o} : bus_rdata;
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // R1: reset state, sampled while reset is held
        rd(A_C, 32'h0, "R1");
        rd(A_T, 32'h0, "R1");
        rd(A_H2, 32'h0, "R1");
        irq_chk(4'h0, "R1");
        @(negedge clk); rst_n = 1'b1;
        // R6: zero window equals zero thresholds, flags set one edge later
        irq_chk(4'hF, "R6");
        // R5: thresholds keep low 16 bits
        wr(A_H0, 32'hDEAD0010); wr(A_H1, 32'h20); wr(A_H2, 32'h30); wr(A_H3, 32'h40);
        rd(A_H0, 32'h10, "R5");
        rd(A_H3, 32'h40, "R5");
        wr(A_C, 32'h0);
        irq_chk(4'h0, "R6");
        // R2: bit 31 of tick reads zero
        wr(A_T, 32'hFFFFFFFF);
        rd(A_T, 32'h7FFFFFFF, "R2");
        rd(A_V, 32'hFFFF, "R4");
        // R4: shifted window reads and writes
        wr(A_C, 32'h4); wr(A_T, 32'h12345);
        rd(A_V, 32'h1234, "R4");
        wr(A_V, 32'hABCD);
        rd(A_T, 32'h000ABCD0, "R4");
        wr(A_C, 32'hF); wr(A_V, 32'hFFFF);
        rd(A_T, 32'h7FFF8000, "R4");
        rd(A_V, 32'hFFFF, "R4");
        // R3: hold when stopped
        wr(A_C, 32'h0); wr(A_T, 32'h5);
        rd(A_T, 32'h5, "R3");
        rd(A_T, 32'h5, "R3");
        // R3: running count and wrap under the run bit
        wr(A_C, 32'h1000); wr(A_T, 32'd10);
        rd(A_T, 32'd10, "R3"); rd(A_T, 32'd11, "R3"); rd(A_T, 32'd12, "R3");
        wr(A_T, 32'h7FFFFFFF);
        rd(A_T, 32'h7FFFFFFF, "R3"); rd(A_T, 32'h0, "R3"); rd(A_T, 32'h1, "R3");
        // R6: one-edge latency from the match to the flag
        wr(A_C, 32'h0); wr(A_T, 32'h0); wr(A_C, 32'h0); wr(A_T, 32'h0E);
        wr(A_C, 32'h1000);
        irq_chk(4'h0, "R6"); irq_chk(4'h0, "R6");
        irq_chk(4'h0, "R6"); irq_chk(4'h1, "R6");
        // R6: flag stays after the match ends, cleared by writing zero
        wr(A_T, 32'h0);
        irq_chk(4'h1, "R6");
        wr(A_C, 32'h1000);
        irq_chk(4'h0, "R6");
        rd(A_C, 32'h00001000, "R6");
        // R7: zero return with the run bit
        wr(A_C, 32'h0); wr(A_T, 32'h0E); wr(A_C, 32'h1200);
        rd(A_T, 32'h0E, "R7"); rd(A_T, 32'h0F, "R7");
        rd(A_T, 32'h10, "R7"); rd(A_T, 32'h0, "R7");
        irq_chk(4'h1, "R7");
        // R7: zero return ends a single pass
        wr(A_C, 32'h0); wr(A_T, 32'h0E); wr(A_C, 32'h2200);
        rd(A_T, 32'h0E, "R7"); rd(A_T, 32'h0F, "R7");
        rd(A_T, 32'h10, "R7"); rd(A_T, 32'h0, "R7"); rd(A_T, 32'h0, "R7");
        rd(A_C, 32'h10000200, "R7");
        // R8: wrap ends a single pass
        wr(A_C, 32'h0); wr(A_T, 32'h7FFFFFFE); wr(A_C, 32'h2000);
        rd(A_T, 32'h7FFFFFFE, "R8"); rd(A_T, 32'h7FFFFFFF, "R8");
        rd(A_T, 32'h0, "R8"); rd(A_T, 32'h0, "R8");
        rd(A_C, 32'hF0000000, "R8");
        // R9: control write on the zero-return edge keeps the single-pass bit
        wr(A_C, 32'h0); wr(A_T, 32'h0E); wr(A_C, 32'h2200);
        rd(A_T, 32'h0E, "R9"); rd(A_T, 32'h0F, "R9");
        wr(A_C, 32'h2200);
        rd(A_T, 32'h0, "R9"); rd(A_T, 32'h1, "R9");
        rd(A_C, 32'h00002200, "R9");
        // R9: tick write on the zero-return edge wins, return follows
        wr(A_C, 32'h0); wr(A_T, 32'h0F); wr(A_C, 32'h1200);
        rd(A_T, 32'h0F, "R9");
        wr(A_T, 32'h1234);
        rd(A_T, 32'h1234, "R9");
        rd(A_T, 32'h0, "R7");
        // R11: unmapped offsets
        wr(8'h04, 32'hFFFFFFFF); wr(8'h30, 32'h12345678);
        rd(8'h04, 32'h0, "R11"); rd(8'h30, 32'h0, "R11");
        rd(A_H0, 32'h10, "R11"); rd(A_H3, 32'h40, "R11");
        // R10: inert control bits stored, no effect on count or flags
        wr(A_C, 32'h0); wr(A_T, 32'h0); wr(A_C, 32'h0F0F0500);
        rd(A_C, 32'h0F0F0500, "R10");
        rd(A_T, 32'h0, "R10");
        irq_chk(4'h0, "R10");
        repeat (2) @(posedge clk);
        done = 1'b1;
        summary();
    end
endmodule